// File: doc/BRIEF.md
# Bang-Bang Proportional-Integral Loop Filter

This block is the digital loop filter of a bang-bang phase-locked loop. It runs on the reference clock. Each reference cycle it may receive a single early/late decision from a binary phase detector, together with a valid strobe. The decision bit stands for a signed unit: +1 when the divided clock leads the reference and −1 when it lags. From that unit the block forms a proportional term, which is the unit shifted left by a programmable amount. It also forms an integral term, which is a saturating accumulator of the unit shifted left by a second programmable amount. The frequency-control word is the sum of a programmable centre code, the proportional term and the updated integral term. Every gain is a power of two, so the datapath uses only shifters and adders.

The control word is registered in the same clock edge that samples the decision. A third shift amount scales the word down arithmetically for a later quantiser. The scaled result has a signed integer part and an 8-bit fraction that keeps every bit shifted out of the integer part. The fraction can hold at most 8 such bits, so any down-scale request above 8 is treated as 8.

A small controller has two states. CENTRE is entered on reset: the output register follows the centre code and the accumulator stays at zero. TRACK is entered on the first valid decision (transition CENTRE→TRACK, named "first decision"). The block then stays in TRACK until reset (transition any→CENTRE, named "reset"). In TRACK each valid decision updates both registers, and a cycle without a decision holds them.

Top module: `bb_pi_filter`

## Requirements
- R1: A synchronous reset (rst=1 at a clock edge) clears the integral accumulator to zero, enters CENTRE and loads centre_code into word_out.
- R2: dec_lead=1 counts as +1 and dec_lead=0 as −1. A valid decision adds ±2^kp_shift (proportional) and the updated integral to centre_code to form word_out.
- R3: Each valid decision adds ±2^ki_shift to the integral accumulator, and the result persists into later cycles.
- R4: The integral accumulator is a 24-bit signed value. It saturates at +8388607 and −8388608 instead of wrapping.
- R5: In TRACK, a cycle with dec_valid=0 leaves word_out and the accumulator unchanged.
- R6: word_out changes only at the clock edge that samples dec_valid=1. Before that edge it still shows the previous value.
- R7: The sum centre_code + proportional + integral saturates to the signed 24-bit range of word_out.
- R8: With e = min(ds_shift, 8), scaled_int equals floor(word_out / 2^e). scaled_frac equals (word_out mod 2^e) · 2^(8−e), so that scaled_int·256 + scaled_frac = word_out·2^(8−e).
- R9: In CENTRE, with no valid decision, word_out follows centre_code one cycle later. The first valid decision moves the block to TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | A decision is present this cycle |
| dec_lead | input | 1 | 1: divided clock leads (+1); 0: lags (−1) |
| kp_shift | input | 4 | Proportional gain exponent |
| ki_shift | input | 4 | Integral gain exponent |
| ds_shift | input | 4 | Down-scale exponent, clamped to 8 |
| centre_code | input | 24 | Signed centre control word |
| word_out | output | 24 | Signed full-precision control word |
| scaled_int | output | 24 | Signed integer part of the scaled word |
| scaled_frac | output | 8 | Fraction bits of the scaled word |

## Verification
A decision applied before a rising edge appears in word_out, scaled_int and scaled_frac after that same edge. The scaled outputs are combinational from word_out, so they add no further delay. The bench drives each decision at a falling edge and first confirms that the outputs still show the old value. It then compares all three outputs against its own model at the next falling edge, exactly one edge later. The same one-edge latency applies to reset and to a centre-code change in CENTRE.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
    localparam int BBF_SH_W = 4;

    typedef enum logic [0:0] {
        ST_CENTRE = 1'b0,
        ST_TRACK  = 1'b1
    } bbf_state_e;
endpackage

// File: rtl/bbf_integrator.sv
module bbf_integrator #(
    parameter int ACC_W = 24,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    up,
    input  logic [SH_W-1:0]         shift,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] acc_nx
);
    localparam int WW = ACC_W + 2;
    localparam logic signed [WW-1:0] ACC_MAX = {3'b000, {(ACC_W-1){1'b1}}};
    localparam logic signed [WW-1:0] ACC_MIN = {3'b111, {(ACC_W-1){1'b0}}};

    logic signed [WW-1:0] step;
    logic signed [WW-1:0] wide;

    always_comb begin
        step = {{(WW-1){1'b0}}, 1'b1} << shift;
        wide = WW'(acc_q) + (up ? step : -step);
        if (!en)
            acc_nx = acc_q;
        else if (wide > ACC_MAX)
            acc_nx = ACC_MAX[ACC_W-1:0];
        else if (wide < ACC_MIN)
            acc_nx = ACC_MIN[ACC_W-1:0];
        else
            acc_nx = wide[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_nx;
    end

    // R3: a lead decision below the ceiling raises the accumulator
    p_up_r3: assert property (@(posedge clk) disable iff (rst)
        (en && up && acc_q != ACC_MAX[ACC_W-1:0]) |=> (acc_q > $past(acc_q)));
    // R2: a lag decision above the floor lowers the accumulator
    p_down_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !up && acc_q != ACC_MIN[ACC_W-1:0]) |=> (acc_q < $past(acc_q)));
    // R4: once at the ceiling, further lead decisions keep it there
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (en && up && acc_q == ACC_MAX[ACC_W-1:0]) |=> (acc_q == ACC_MAX[ACC_W-1:0]));
    // R5: no decision, no change
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(acc_q));
endmodule

// File: rtl/bbf_scaler.sv
module bbf_scaler #(
    parameter int W      = 24,
    parameter int FRAC_W = 8,
    parameter int SH_W   = 4
) (
    input  logic signed [W-1:0]  word,
    input  logic [SH_W-1:0]      ds,
    output logic signed [W-1:0]  int_part,
    output logic [FRAC_W-1:0]    frac_part
);
    localparam int EW = W + FRAC_W;

    logic [SH_W-1:0]      eff;
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] shd;

    always_comb begin
        eff       = (32'(ds) > FRAC_W) ? SH_W'(FRAC_W) : ds;
        ext       = {word, {FRAC_W{1'b0}}};
        shd       = ext >>> eff;
        int_part  = shd[EW-1:FRAC_W];
        frac_part = shd[FRAC_W-1:0];
    end
endmodule

// File: rtl/bb_pi_filter.sv
module bb_pi_filter
    import bbf_pkg::*;
#(
    parameter int W      = 24,
    parameter int FRAC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dec_valid,
    input  logic                 dec_lead,
    input  logic [BBF_SH_W-1:0]  kp_shift,
    input  logic [BBF_SH_W-1:0]  ki_shift,
    input  logic [BBF_SH_W-1:0]  ds_shift,
    input  logic signed [W-1:0]  centre_code,
    output logic signed [W-1:0]  word_out,
    output logic signed [W-1:0]  scaled_int,
    output logic [FRAC_W-1:0]    scaled_frac
);
    localparam int SW = W + 3;
    localparam logic signed [SW-1:0] OUT_MAX = {4'b0000, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] OUT_MIN = {4'b1111, {(W-1){1'b0}}};

    bbf_state_e state_q, state_nx;

    logic signed [W-1:0]  acc_q, acc_nx;
    logic signed [SW-1:0] pstep, pterm, sum;
    logic signed [W-1:0]  sum_sat;

    bbf_integrator #(.ACC_W(W), .SH_W(BBF_SH_W)) u_integ (
        .clk   (clk),
        .rst   (rst),
        .en    (dec_valid),
        .up    (dec_lead),
        .shift (ki_shift),
        .acc_q (acc_q),
        .acc_nx(acc_nx)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_CENTRE: if (dec_valid) state_nx = ST_TRACK;
            ST_TRACK:  state_nx = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CENTRE;
        else     state_q <= state_nx;
    end

    always_comb begin
        pstep = {{(SW-1){1'b0}}, 1'b1} << kp_shift;
        pterm = dec_lead ? pstep : -pstep;
        sum   = SW'(centre_code) + pterm + SW'(acc_nx);
        if (sum > OUT_MAX)      sum_sat = OUT_MAX[W-1:0];
        else if (sum < OUT_MIN) sum_sat = OUT_MIN[W-1:0];
        else                    sum_sat = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_out <= centre_code;
        else if (dec_valid)
            word_out <= sum_sat;
        else if (state_q == ST_CENTRE)
            word_out <= centre_code;
    end

    bbf_scaler #(.W(W), .FRAC_W(FRAC_W), .SH_W(BBF_SH_W)) u_scale (
        .word     (word_out),
        .ds       (ds_shift),
        .int_part (scaled_int),
        .frac_part(scaled_frac)
    );

    // R1: reset loads the centre code and clears the integral
    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (word_out == $past(centre_code) && acc_q == '0 && state_q == ST_CENTRE));
    // R5: tracking without a decision holds the word
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRACK && !dec_valid) |=> $stable(word_out));
    // R9: centre state follows the centre code
    p_centre_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CENTRE && !dec_valid) |=> (word_out == $past(centre_code)));
    // R9: a decision always leaves the controller tracking
    p_enter_track_r9: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> (state_q == ST_TRACK));
endmodule

// File: tb/bb_pi_filter_bench.sv
module bb_pi_filter_bench;
    localparam longint OMAX = 64'sd8388607;
    localparam longint OMIN = -64'sd8388608;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_valid = 1'b0;
    logic dec_lead = 1'b0;
    logic [3:0] kp_shift = 4'd5;
    logic [3:0] ki_shift = 4'd0;
    logic [3:0] ds_shift = 4'd0;
    logic signed [23:0] centre_code = 24'sd1000;
    logic signed [23:0] word_out, scaled_int;
    logic [7:0] scaled_frac;

    int checks = 0;
    int failures = 0;
    longint m_int = 0, m_word = 0;
    bit m_track = 0;

    always #2.5 clk = ~clk;

    bb_pi_filter u_bb_pi_filter (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_lead(dec_lead),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .ds_shift(ds_shift),
        .centre_code(centre_code), .word_out(word_out),
        .scaled_int(scaled_int), .scaled_frac(scaled_frac)
    );

    function automatic longint clip(input longint v);
        if (v > OMAX) return OMAX;
        if (v < OMIN) return OMIN;
        return v;
    endfunction

    function automatic longint pw2(input int e);
        return 64'sd1 <<< e;
    endfunction

    function automatic longint exp_int(input longint w, input int ds);
        int e = (ds > 8) ? 8 : ds;
        return w >>> e;
    endfunction

    function automatic longint exp_frac(input longint w, input int ds);
        int e = (ds > 8) ? 8 : ds;
        return (w & (pw2(e) - 1)) <<< (8 - e);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, longint'(word_out), m_word);
        check("R8 int", longint'(scaled_int), exp_int(m_word, int'(ds_shift)));
        check("R8 frac", longint'(scaled_frac), exp_frac(m_word, int'(ds_shift)));
    endtask

    // drive one cycle at the falling edge, advance the model, compare one edge later
    task automatic step(input bit v, input bit lead, input string tag);
        longint s;
        dec_valid = v;
        dec_lead = lead;
        #0.1;
        check("R6 before edge", longint'(word_out), m_word);
        @(posedge clk);
        if (v) begin
            s = lead ? 1 : -1;
            m_int = clip(m_int + s * pw2(int'(ki_shift)));
            m_word = clip(longint'(centre_code) + s * pw2(int'(kp_shift)) + m_int);
            m_track = 1;
        end else if (!m_track) begin
            m_word = longint'(centre_code);
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        dec_valid = 1'b0;
        @(posedge clk);
        m_int = 0; m_track = 0; m_word = longint'(centre_code);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        do_reset();

        // R9: centre follows before the first decision
        centre_code = -24'sd777;
        step(0, 0, "R9 follow centre");
        centre_code = 24'sd1000;
        step(0, 0, "R9 follow centre");

        // R2, R3: signed steps
        kp_shift = 4'd5; ki_shift = 4'd0;
        step(1, 1, "R2 lead");
        step(1, 0, "R2 lag");
        step(1, 1, "R3 accumulate");
        step(1, 1, "R3 accumulate");
        centre_code = 24'sd5;
        step(0, 0, "R5 hold");
        step(0, 1, "R5 hold");
        ds_shift = 4'd3; step(0, 0, "R8 ds3");
        ds_shift = 4'd12; step(0, 0, "R8 ds clamp");
        centre_code = 24'sd1000;

        // R4, R7: drive to both saturation limits
        do_reset();
        kp_shift = 4'd15; ki_shift = 4'd15; ds_shift = 4'd8;
        for (int i = 0; i < 300; i++) step(1, 1, "R4 R7 upper");
        for (int i = 0; i < 600; i++) step(1, 0, "R4 R7 lower");
        centre_code = -24'sd8388000;
        step(1, 0, "R7 low clip");

        // constrained random
        centre_code = 24'sd0;
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 64) == 0) begin
                ki_shift = 4'($urandom % 11);
                kp_shift = 4'(ki_shift + 5);
                ds_shift = 4'($urandom % 16);
                centre_code = 24'($signed($urandom % 200000) - 100000);
            end
            if (($urandom % 500) == 0) do_reset();
            else step(($urandom % 4) != 0, $urandom % 2, "R3 R5 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule